// File: doc/BRIEF.md
# Posted Store Write Buffer

This block sits between a processor's data port and a slower system bus and lets stores retire before the bus has taken them. The processor pushes typed 64-bit entries into a sixteen-deep queue; a drain engine removes them one at a time and presents each data entry to the bus as a single write. The time each write takes depends on its size, on whether it continues a burst, and on whether its target is the main-memory region. Main memory has its own busy timer. Every other region imposes a short gap between writes.

An entry keeps its kind code in bits 63:61 and a 32-bit value in bits 31:0. A marker entry carries an address and sets the target of the data entries that follow it. A single store therefore pushes a marker and then a data entry. A burst pushes one nonsequential word and then sequential words, whose addresses advance by four on their own. The region of the last completed write is remembered. A read to that region while the drain engine is still busy raises a one-cycle penalty flag. A drain request input blocks new entries until the buffer runs empty, so the processor can wait for a clean bus before an access that must not be buffered.

Top module: `store_post_buffer`

## Requirements
- R1: The buffer holds up to 16 entries. With 16 stored, push_ready is low. It rises again in the cycle after an entry has left. Data entries reach the bus in the order they were pushed.
- R2: Kind codes are 0 byte, 1 halfword, 2 nonsequential word, 3 sequential word and 4 address marker. A bus write shows bus_size 0 for a byte, 1 for a halfword and 2 for a word. bus_seq is 1 only for kind 3.
- R3: A marker at the head is removed in one cycle and never produces a bus write. Its value becomes the address of the following data writes. A completed word write (kind 2 or 3) advances that address by 4.
- R4: An entry with kind 5, 6 or 7 is removed without a bus write. bad_kind is high for exactly the cycle in which it is removed.
- R5: An entry pushed into an empty buffer can start draining in the cycle after it is accepted. A write that starts in cycle s shows bus_wr, for one cycle, in cycle s+D, with D taken from R6. For example, a byte to a non-main region accepted into an idle buffer in cycle a appears on the bus in cycle a+5.
- R6: Main memory is address bits 31:24 equal to 0x02. There, D is 3 for a byte, 2 for a halfword, 3 for a nonsequential word and 2 for a sequential word. In other regions D is 4 for any nonsequential write and 2 for a sequential word.
- R7: After a main-memory write completes in cycle c, no main-memory write starts in the next 4 cycles (byte) or 5 cycles (any other kind).
- R8: After a non-main write completes in cycle c, no data write starts in cycles c+1 and c+2. Markers may still be removed in those cycles.
- R9: In the cycle after a non-marker entry is accepted, push_ready is low for non-marker kinds and high for a marker, if the buffer is not full.
- R10: While drain_all is high, push_ready is low. empty is high exactly when no entry is stored and no write is in flight.
- R11: rd_extra is high when rd_req is high, at least one write has completed, bits 31:24 of rd_addr equal the region of the last completed write, and the drain engine is busy: a write is in flight, or the gap of R8 or the hold of R7 is running.
- R12: After reset, empty and push_ready are high, and bus_wr, bad_kind and rd_extra are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Entry offered this cycle |
| push_kind | input | 3 | Kind code of the offered entry |
| push_data | input | 32 | Data value, or address for a marker |
| push_ready | output | 1 | Entry accepted when high together with push_valid |
| drain_all | input | 1 | Block new entries until the buffer is empty |
| empty | output | 1 | No stored entry and no write in flight |
| rd_req | input | 1 | Processor read issued this cycle |
| rd_addr | input | 32 | Address of that read |
| rd_extra | output | 1 | Read pays one extra bus cycle |
| bus_wr | output | 1 | Bus write completes this cycle |
| bus_addr | output | 32 | Bus write address |
| bus_data | output | 32 | Bus write data |
| bus_size | output | 2 | 0 byte, 1 halfword, 2 word |
| bus_seq | output | 1 | Write continues a burst |
| bad_kind | output | 1 | Entry with an invalid kind was discarded |

## Verification
Single stores to an ordinary region and to main memory are compared with each other. Equal patterns with different cycle spacing show whether the 2-cycle gap or the 4- or 5-cycle main hold has been applied. Byte-then-byte and halfword-then-byte pairs in main memory tell the shorter byte hold apart from the longer one. A burst of one nonsequential word followed by sequential words checks that the address steps by four and that the sequence flag is correct. A run of forty burst words pushed faster than they drain fills the queue and exercises the full stall. Further cases cover invalid kinds, a drain request, and reads to the last region written while the engine is busy and after it has gone quiet.

// File: rtl/spb_pkg.sv
package spb_pkg;

  localparam logic [2:0] KIND_BYTE = 3'd0;
  localparam logic [2:0] KIND_HALF = 3'd1;
  localparam logic [2:0] KIND_WORD = 3'd2;
  localparam logic [2:0] KIND_WSEQ = 3'd3;
  localparam logic [2:0] KIND_MARK = 3'd4;

  typedef struct packed {
    logic [2:0]  kind;
    logic [28:0] rsvd;
    logic [31:0] val;
  } spb_entry_t;

endpackage

// File: rtl/spb_fifo.sv
module spb_fifo
  import spb_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_i,
  input  spb_entry_t push_entry_i,
  input  logic       pop_i,
  output spb_entry_t head_o,
  output logic       empty_o,
  output logic       full_o
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W:0] EMPTY_CODE = (PTR_W + 1)'(DEPTH);

  spb_entry_t       store_q [DEPTH];
  logic [PTR_W-1:0] fill_q, fill_d;
  logic [PTR_W:0]   take_q, take_d;
  logic [PTR_W-1:0] take_inc;

  assign empty_o  = (take_q == EMPTY_CODE);
  assign full_o   = !empty_o && (take_q[PTR_W-1:0] == fill_q);
  assign head_o   = store_q[take_q[PTR_W-1:0]];
  assign take_inc = take_q[PTR_W-1:0] + 1'b1;

  always_comb begin
    fill_d = fill_q;
    take_d = take_q;
    if (push_i) fill_d = fill_q + 1'b1;
    if (pop_i) begin
      if ((take_inc == fill_q) && !push_i) take_d = EMPTY_CODE;
      else                                 take_d = {1'b0, take_inc};
    end else if (empty_o && push_i) begin
      take_d = {1'b0, fill_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      take_q <= EMPTY_CODE;
    end else begin
      fill_q <= fill_d;
      take_q <= take_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) store_q[fill_q] <= push_entry_i;
  end

  a_r1_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  a_r1_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);

endmodule

// File: rtl/spb_drain.sv
module spb_drain
  import spb_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int REG_LSB       = 24,
  parameter int REG_W         = 8,
  parameter logic [REG_W-1:0] MAIN_REGION = 8'h02,
  parameter int MAIN_BYTE_CYC = 3,
  parameter int MAIN_HALF_CYC = 2,
  parameter int MAIN_WORD_CYC = 3,
  parameter int SEQ_CYC       = 2,
  parameter int OTHER_NS_CYC  = 4,
  parameter int HOLD_BYTE_CYC = 4,
  parameter int HOLD_OTHER_CYC = 5,
  parameter int GAP_CYC       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  spb_entry_t        head_i,
  input  logic              head_valid_i,
  output logic              pop_o,
  output logic              bus_wr_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [31:0]       bus_data_o,
  output logic [1:0]        bus_size_o,
  output logic              bus_seq_o,
  output logic              bad_kind_o,
  output logic              idle_o,
  output logic              active_o,
  output logic [REG_W-1:0]  last_region_o,
  output logic              last_valid_o
);

  localparam int T_SUM = MAIN_BYTE_CYC + MAIN_HALF_CYC + MAIN_WORD_CYC + SEQ_CYC +
                         OTHER_NS_CYC + HOLD_BYTE_CYC + HOLD_OTHER_CYC + GAP_CYC;
  localparam int CNT_W = $clog2(T_SUM + 1);

  logic [CNT_W-1:0]  busy_q, busy_d;
  logic [CNT_W-1:0]  gap_q, gap_d;
  logic [CNT_W-1:0]  hold_q, hold_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [31:0]       wdata_q, wdata_d;
  logic [2:0]        wkind_q, wkind_d;
  logic [REG_W-1:0]  lreg_q, lreg_d;
  logic              lval_q, lval_d;

  logic is_mark, is_data, is_bad, free, tgt_main, start, take_mark, drop, done;
  logic unused_rsvd;

  assign unused_rsvd = ^head_i.rsvd;

  function automatic logic [CNT_W-1:0] dur_of(input logic [2:0] k, input logic m);
    if (k == KIND_WSEQ)      return CNT_W'(SEQ_CYC);
    else if (!m)             return CNT_W'(OTHER_NS_CYC);
    else if (k == KIND_BYTE) return CNT_W'(MAIN_BYTE_CYC);
    else if (k == KIND_HALF) return CNT_W'(MAIN_HALF_CYC);
    else                     return CNT_W'(MAIN_WORD_CYC);
  endfunction

  assign is_mark   = (head_i.kind == KIND_MARK);
  assign is_data   = (head_i.kind <= KIND_WSEQ);
  assign is_bad    = !is_mark && !is_data;
  assign free      = (busy_q == '0);
  assign tgt_main  = (addr_q[REG_LSB +: REG_W] == MAIN_REGION);
  assign start     = head_valid_i && free && is_data && (gap_q == '0) &&
                     (!tgt_main || (hold_q == '0));
  assign take_mark = head_valid_i && free && is_mark;
  assign drop      = head_valid_i && free && is_bad;
  assign done      = (busy_q == CNT_W'(1));

  assign pop_o         = start || take_mark || drop;
  assign bus_wr_o      = done;
  assign bus_addr_o    = addr_q;
  assign bus_data_o    = wdata_q;
  assign bus_size_o    = (wkind_q == KIND_BYTE) ? 2'd0 : (wkind_q == KIND_HALF) ? 2'd1 : 2'd2;
  assign bus_seq_o     = (wkind_q == KIND_WSEQ);
  assign bad_kind_o    = drop;
  assign idle_o        = free;
  assign active_o      = !free || (gap_q != '0) || (hold_q != '0);
  assign last_region_o = lreg_q;
  assign last_valid_o  = lval_q;

  always_comb begin
    busy_d  = (busy_q != '0) ? busy_q - 1'b1 : busy_q;
    gap_d   = (gap_q  != '0) ? gap_q  - 1'b1 : gap_q;
    hold_d  = (hold_q != '0) ? hold_q - 1'b1 : hold_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    wkind_d = wkind_q;
    lreg_d  = lreg_q;
    lval_d  = lval_q;
    if (take_mark) addr_d = head_i.val[ADDR_W-1:0];
    if (start) begin
      busy_d  = dur_of(head_i.kind, tgt_main);
      wdata_d = head_i.val;
      wkind_d = head_i.kind;
    end
    if (done) begin
      if (tgt_main) hold_d = (wkind_q == KIND_BYTE) ? CNT_W'(HOLD_BYTE_CYC) : CNT_W'(HOLD_OTHER_CYC);
      else          gap_d  = CNT_W'(GAP_CYC);
      if ((wkind_q == KIND_WORD) || (wkind_q == KIND_WSEQ)) addr_d = addr_q + ADDR_W'(4);
      lreg_d = addr_q[REG_LSB +: REG_W];
      lval_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= '0;
      gap_q   <= '0;
      hold_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      wkind_q <= KIND_BYTE;
      lreg_q  <= '0;
      lval_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      gap_q  <= gap_d;
      hold_q <= hold_d;
      if (take_mark || done) addr_q <= addr_d;
      if (start) begin
        wdata_q <= wdata_d;
        wkind_q <= wkind_d;
      end
      if (done) begin
        lreg_q <= lreg_d;
        lval_q <= lval_d;
      end
    end
  end

  a_r4_no_marker_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_o |-> (wkind_q <= KIND_WSEQ));
  a_r8_gap_after_other: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_o && !tgt_main) |=> !start);
  a_r7_main_hold_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_o && tgt_main) |=> (hold_q != '0));
  a_r5_no_instant_write: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !bus_wr_o);
  a_r3_addr_frozen_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (!free && !done) |=> $stable(addr_q));

endmodule

// File: rtl/spb_rdguard.sv
module spb_rdguard #(
  parameter int ADDR_W  = 32,
  parameter int REG_LSB = 24,
  parameter int REG_W   = 8
) (
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [REG_W-1:0]  last_region_i,
  input  logic              last_valid_i,
  input  logic              active_i,
  output logic              rd_extra_o
);

  logic unused_addr;

  assign unused_addr = ^{rd_addr_i[REG_LSB-1:0]};
  assign rd_extra_o  = rd_req_i && last_valid_i && active_i &&
                       (rd_addr_i[REG_LSB +: REG_W] == last_region_i);

endmodule

// File: rtl/store_post_buffer.sv
module store_post_buffer
  import spb_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int ADDR_W  = 32,
  parameter int REG_LSB = 24,
  parameter int REG_W   = 8,
  parameter logic [REG_W-1:0] MAIN_REGION = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [2:0]        push_kind,
  input  logic [31:0]       push_data,
  output logic              push_ready,
  input  logic              drain_all,
  output logic              empty,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_extra,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_data,
  output logic [1:0]        bus_size,
  output logic              bus_seq,
  output logic              bad_kind
);

  spb_entry_t       push_entry, head;
  logic             fifo_empty, fifo_full, pop, accept, spacing_q, spacing_d;
  logic             drain_idle, drain_active, last_valid;
  logic [REG_W-1:0] last_region;

  assign push_entry = '{kind: push_kind, rsvd: '0, val: push_data};
  assign push_ready = !drain_all && !fifo_full && !(spacing_q && (push_kind != KIND_MARK));
  assign accept     = push_valid && push_ready;
  assign spacing_d  = accept && (push_kind != KIND_MARK);
  assign empty      = fifo_empty && drain_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spacing_q <= 1'b0;
    else        spacing_q <= spacing_d;
  end

  spb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(accept), .push_entry_i(push_entry),
    .pop_i(pop), .head_o(head), .empty_o(fifo_empty), .full_o(fifo_full)
  );

  spb_drain #(
    .ADDR_W(ADDR_W), .REG_LSB(REG_LSB), .REG_W(REG_W), .MAIN_REGION(MAIN_REGION)
  ) u_drain (
    .clk(clk), .rst_n(rst_n), .head_i(head), .head_valid_i(!fifo_empty), .pop_o(pop),
    .bus_wr_o(bus_wr), .bus_addr_o(bus_addr), .bus_data_o(bus_data),
    .bus_size_o(bus_size), .bus_seq_o(bus_seq), .bad_kind_o(bad_kind),
    .idle_o(drain_idle), .active_o(drain_active),
    .last_region_o(last_region), .last_valid_o(last_valid)
  );

  spb_rdguard #(.ADDR_W(ADDR_W), .REG_LSB(REG_LSB), .REG_W(REG_W)) u_rdguard (
    .rd_req_i(rd_req), .rd_addr_i(rd_addr), .last_region_i(last_region),
    .last_valid_i(last_valid), .active_i(drain_active), .rd_extra_o(rd_extra)
  );

  a_r9_store_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (push_kind != KIND_MARK)) |=> !(accept && (push_kind != KIND_MARK)));
  a_r10_drain_blocks_push: assert property (@(posedge clk) disable iff (!rst_n)
    drain_all |-> !accept);
  a_r11_extra_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
    rd_extra |-> last_valid);
  a_r10_empty_means_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> !bus_wr);

endmodule

// File: tb/tb_store_post_buffer.sv
`timescale 1ns/1ps
module tb_store_post_buffer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        push_valid, drain_all, rd_req;
  logic [2:0]  push_kind;
  logic [31:0] push_data, rd_addr;
  logic        push_ready, empty, rd_extra, bus_wr, bus_seq, bad_kind;
  logic [31:0] bus_addr, bus_data;
  logic [1:0]  bus_size;

  always #4 clk = ~clk;

  store_post_buffer dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_kind(push_kind),
    .push_data(push_data), .push_ready(push_ready), .drain_all(drain_all), .empty(empty),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_extra(rd_extra), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_size(bus_size), .bus_seq(bus_seq),
    .bad_kind(bad_kind)
  );

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int          mq_k[$];
  logic [31:0] mq_v[$];
  int          m_busy, m_gap, m_hold, m_wkind, m_lreg;
  logic [31:0] m_addr, m_wdata;
  bit          m_lval, m_space;

  function automatic bit m_main(input logic [31:0] a);
    return a[31:24] == 8'h02;
  endfunction
  function automatic int m_dur(input int k, input bit mn);
    if (k == 3) return 2;
    if (!mn) return 4;
    if (k == 1) return 2;
    return 3;
  endfunction
  function automatic bit m_ready();
    return !drain_all && (mq_k.size() < 16) && !(m_space && push_kind != 3'd4);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq_k.delete(); mq_v.delete();
      m_busy = 0; m_gap = 0; m_hold = 0; m_wkind = 0; m_lreg = 0;
      m_addr = 0; m_wdata = 0; m_lval = 0; m_space = 0;
    end else begin
      bit acc, done;
      int st;
      acc  = push_valid && m_ready();
      done = (m_busy == 1);
      st   = 0;
      if (m_busy == 0 && mq_k.size() > 0) begin
        if (mq_k[0] == 4) begin
          m_addr = mq_v[0]; void'(mq_k.pop_front()); void'(mq_v.pop_front());
        end else if (mq_k[0] > 4) begin
          void'(mq_k.pop_front()); void'(mq_v.pop_front());
        end else if (m_gap == 0 && (!m_main(m_addr) || m_hold == 0)) begin
          m_wkind = mq_k[0]; m_wdata = mq_v[0]; st = m_dur(m_wkind, m_main(m_addr));
          void'(mq_k.pop_front()); void'(mq_v.pop_front());
        end
      end
      if (m_gap > 0) m_gap--;
      if (m_hold > 0) m_hold--;
      if (m_busy > 0) m_busy--;
      if (done) begin
        if (m_main(m_addr)) m_hold = (m_wkind == 0) ? 4 : 5;
        else m_gap = 2;
        m_lreg = m_addr[31:24]; m_lval = 1;
        if (m_wkind >= 2) m_addr = m_addr + 4;
      end
      if (st != 0) m_busy = st;
      if (acc) begin mq_k.push_back(int'(push_kind)); mq_v.push_back(push_data); end
      m_space = acc && push_kind != 3'd4;
    end
  end

  // per-cycle comparison and write monitor
  logic [31:0] obs_addr[$], obs_data[$];
  int          obs_cyc[$], obs_size[$], obs_seq[$];
  int          bad_seen = 0, extra_seen = 0;
  bit          full_seen = 0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit e_wr, e_bad, e_empty, e_rdx;
      e_wr    = (m_busy == 1);
      e_bad   = (m_busy == 0 && mq_k.size() > 0 && mq_k[0] > 4);
      e_empty = (mq_k.size() == 0 && m_busy == 0);
      e_rdx   = rd_req && m_lval && (rd_addr[31:24] == m_lreg[7:0]) &&
                (m_busy != 0 || m_gap != 0 || m_hold != 0);
      check(push_ready == m_ready(), "R9 R10 R1 push_ready", push_ready, m_ready());
      check(bus_wr == e_wr, "R5 R6 bus_wr timing", bus_wr, e_wr);
      check(bad_kind == e_bad, "R4 bad_kind", bad_kind, e_bad);
      check(empty == e_empty, "R10 empty", empty, e_empty);
      check(rd_extra == e_rdx, "R11 rd_extra", rd_extra, e_rdx);
      if (e_wr && bus_wr) begin
        check(bus_addr == m_addr, "R3 bus_addr", bus_addr, m_addr);
        check(bus_data == m_wdata, "R6 bus_data", bus_data, m_wdata);
        check(bus_size == ((m_wkind == 0) ? 2'd0 : (m_wkind == 1) ? 2'd1 : 2'd2),
              "R2 bus_size", bus_size, m_wkind);
        check(bus_seq == (m_wkind == 3), "R2 bus_seq", bus_seq, m_wkind);
      end
      if (bus_wr) begin
        obs_addr.push_back(bus_addr); obs_data.push_back(bus_data); obs_cyc.push_back(cyc);
        obs_size.push_back(int'(bus_size)); obs_seq.push_back(int'(bus_seq));
      end
      if (bad_kind) bad_seen++;
      if (rd_extra) extra_seen++;
      if (mq_k.size() == 16 && !push_ready) full_seen = 1;
    end
  end

  always @(posedge clk) cyc++;

  task automatic do_push(input logic [2:0] k, input logic [31:0] v, output int acc_cyc);
    push_valid = 1'b1; push_kind = k; push_data = v;
    forever begin
      @(negedge clk);
      if (push_ready) begin
        acc_cyc = cyc;
        @(posedge clk); #1;
        break;
      end
      @(posedge clk); #1;
    end
    push_valid = 1'b0; push_kind = 3'd0;
  endtask

  task automatic wait_idle();
    forever begin
      @(negedge clk);
      if (empty && m_gap == 0 && m_hold == 0) break;
    end
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic clear_obs();
    obs_addr.delete(); obs_data.delete(); obs_cyc.delete(); obs_size.delete(); obs_seq.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int a, b, d;
    rst_n = 1'b0; push_valid = 0; push_kind = 0; push_data = 0; drain_all = 0;
    rd_req = 1'b1; rd_addr = 32'h0400_1000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(empty == 1'b1, "R12 reset empty", empty, 1);
    check(push_ready == 1'b1, "R12 reset push_ready", push_ready, 1);
    check(bus_wr == 1'b0 && bad_kind == 1'b0 && rd_extra == 1'b0, "R12 reset outputs", {bus_wr, bad_kind, rd_extra}, 0);
    @(posedge clk); #1;

    // non-main single byte into idle buffer
    clear_obs();
    do_push(3'd4, 32'h0400_0010, a);
    do_push(3'd0, 32'h0000_00AB, a);
    wait_idle();
    check(obs_cyc.size() == 1, "R5 one write", obs_cyc.size(), 1);
    if (obs_cyc.size() == 1) begin
      check(obs_cyc[0] - a == 5, "R5 idle byte latency", obs_cyc[0] - a, 5);
      check(obs_addr[0] == 32'h0400_0010, "R3 marker address", obs_addr[0], 32'h0400_0010);
      check(obs_size[0] == 0, "R2 byte size", obs_size[0], 0);
    end

    // non-main pair: gap spacing, store spacing, read penalty
    clear_obs(); extra_seen = 0;
    do_push(3'd4, 32'h0400_0020, a);
    do_push(3'd0, 32'h0000_0011, a);
    push_valid = 1'b1; push_kind = 3'd0; push_data = 32'h22;
    @(negedge clk);
    check(push_ready == 1'b0, "R9 data held off after data", push_ready, 0);
    @(posedge clk); #1;
    push_valid = 1'b0;
    do_push(3'd4, 32'h0400_0024, a);
    do_push(3'd0, 32'h0000_0022, a);
    wait_idle();
    check(obs_cyc.size() == 2, "R8 two writes", obs_cyc.size(), 2);
    if (obs_cyc.size() == 2) check(obs_cyc[1] - obs_cyc[0] == 7, "R8 other-region spacing", obs_cyc[1] - obs_cyc[0], 7);
    check(extra_seen > 0, "R11 read to last region stalls", extra_seen, 1);
    @(negedge clk);
    check(rd_extra == 1'b0, "R11 quiet buffer no stall", rd_extra, 0);
    @(posedge clk); #1;

    // main memory: byte after byte, byte after halfword
    clear_obs();
    do_push(3'd4, 32'h0200_0000, a);
    do_push(3'd0, 32'h0000_0001, a);
    do_push(3'd4, 32'h0200_0004, b);
    do_push(3'd0, 32'h0000_0002, b);
    wait_idle();
    check(obs_cyc.size() == 2, "R7 two main writes", obs_cyc.size(), 2);
    if (obs_cyc.size() == 2) begin
      check(obs_cyc[0] - a == 4, "R6 main byte latency", obs_cyc[0] - a, 4);
      check(obs_cyc[1] - obs_cyc[0] == 8, "R7 hold after main byte", obs_cyc[1] - obs_cyc[0], 8);
    end
    clear_obs();
    do_push(3'd4, 32'h0200_0100, a);
    do_push(3'd1, 32'h0000_BEEF, a);
    do_push(3'd4, 32'h0200_0108, b);
    do_push(3'd0, 32'h0000_0003, b);
    wait_idle();
    check(obs_cyc.size() == 2, "R7 half then byte", obs_cyc.size(), 2);
    if (obs_cyc.size() == 2) begin
      check(obs_cyc[0] - a == 3, "R6 main half latency", obs_cyc[0] - a, 3);
      check(obs_cyc[1] - obs_cyc[0] == 9, "R7 hold after main half", obs_cyc[1] - obs_cyc[0], 9);
      check(obs_size[0] == 1, "R2 half size", obs_size[0], 1);
    end

    // burst addressing
    clear_obs();
    do_push(3'd4, 32'h0600_0100, a);
    do_push(3'd2, 32'h0000_00A0, a);
    do_push(3'd3, 32'h0000_00A1, a);
    do_push(3'd3, 32'h0000_00A2, a);
    wait_idle();
    check(obs_cyc.size() == 3, "R3 burst writes", obs_cyc.size(), 3);
    if (obs_cyc.size() == 3) begin
      check(obs_addr[1] == 32'h0600_0104 && obs_addr[2] == 32'h0600_0108, "R3 burst address step", obs_addr[2], 32'h0600_0108);
      check(obs_seq[0] == 0 && obs_seq[1] == 1 && obs_seq[2] == 1, "R2 seq flags", {obs_seq[0], obs_seq[1], obs_seq[2]}, 3);
    end

    // invalid kind
    clear_obs(); bad_seen = 0;
    do_push(3'd5, 32'h1234_5678, a);
    wait_idle();
    check(bad_seen == 1, "R4 invalid kind flagged once", bad_seen, 1);
    check(obs_cyc.size() == 0, "R4 invalid kind not written", obs_cyc.size(), 0);

    // fill to capacity
    clear_obs(); full_seen = 0;
    do_push(3'd4, 32'h0500_0000, a);
    do_push(3'd2, 32'h0000_0000, a);
    for (int i = 1; i < 40; i++) do_push(3'd3, i, a);
    wait_idle();
    check(full_seen == 1, "R1 full stall seen", full_seen, 1);
    check(obs_cyc.size() == 40, "R1 no entry lost", obs_cyc.size(), 40);
    if (obs_cyc.size() == 40) begin
      check(obs_data[39] == 32'd39, "R1 order kept", obs_data[39], 39);
      check(obs_addr[39] == 32'h0500_009C, "R3 long burst address", obs_addr[39], 32'h0500_009C);
    end

    // drain request
    clear_obs();
    do_push(3'd4, 32'h0400_0200, a);
    do_push(3'd2, 32'h0000_0055, a);
    do_push(3'd3, 32'h0000_0056, a);
    drain_all = 1'b1; push_valid = 1'b1; push_kind = 3'd4;
    @(negedge clk);
    check(push_ready == 1'b0, "R10 drain blocks push", push_ready, 0);
    @(posedge clk); #1;
    push_valid = 1'b0;
    d = 0;
    while (!empty && d < 100) begin @(negedge clk); d++; end
    check(empty == 1'b1, "R10 drained to empty", empty, 1);
    check(obs_cyc.size() == 2, "R10 all writes out", obs_cyc.size(), 2);
    @(posedge clk); #1 drain_all = 1'b0;
    repeat (8) @(posedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule